// File: doc/BRIEF.md
# Periodic Tick and Bus-Condition Detector

This block divides a 6 MHz clock into two periodic interrupt sources. A short tick arrives every 128 µs, which is 768 clock cycles, and a long tick arrives on every eighth short tick, which is about 1.024 ms. Each tick can set its own pending interrupt request when that request's enable is high. The timer runs freely from reset and does not depend on any enable, so turning an enable on never moves the tick phase.

A third request comes from a line-condition detector. A mode input selects what it watches. In one mode it looks for a USB bus reset, where both data lines are low. In the other mode it looks for PS/2 activity, where the clock line or the data line is low. The detector samples the selected condition only on the short tick, so the request is raised after the condition has lasted between 128 µs and 256 µs. Each request stays pending until software acknowledges it.

Top module: `tick_irq_ctrl`

## Requirements
- R1: During and after reset all three requests are low, and the tick counters restart from zero.
- R2: The short tick occurs every 768 cycles. The first one comes 768 rising edges after reset is released. When `fast_en_i` is high, the short request goes high on the clock edge that follows the tick.
- R3: The long tick coincides with every eighth short tick, so it repeats every 6144 cycles. When `slow_en_i` is high, the long request goes high on the edge that follows it.
- R4: With `det_mode_i`=0 the condition is `usb_dp_i`=0 and `usb_dm_i`=0 together. With `det_mode_i`=1 the condition is `ps2_clk_i`=0 or `ps2_dat_i`=0. A line pattern that does not satisfy the selected condition never raises the detector request.
- R5: The detector sets its request on a short tick where the condition is true and was also true at the previous short tick. A false sample clears the history. A condition that stays true sets the request only once per episode.
- R6: A pending request stays high until its acknowledge is sampled high. If a set event and an acknowledge happen in the same cycle, the set event wins.
- R7: While an enable is low, its request is cleared on the next edge and cannot be set.
- R8: Changing the enables does not reset or shift the tick timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 6 MHz clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fast_en_i | input | 1 | Enable for the 128 µs request |
| slow_en_i | input | 1 | Enable for the 1.024 ms request |
| det_en_i | input | 1 | Enable for the detector request |
| det_mode_i | input | 1 | 0: USB bus reset, 1: PS/2 activity |
| usb_dp_i | input | 1 | USB D+ line level |
| usb_dm_i | input | 1 | USB D- line level |
| ps2_clk_i | input | 1 | PS/2 clock line level |
| ps2_dat_i | input | 1 | PS/2 data line level |
| fast_ack_i | input | 1 | Acknowledge for the short request |
| slow_ack_i | input | 1 | Acknowledge for the long request |
| det_ack_i | input | 1 | Acknowledge for the detector request |
| fast_irq_o | output | 1 | 128 µs request |
| slow_irq_o | output | 1 | 1.024 ms request |
| det_irq_o | output | 1 | Line-condition request |

## Verification
A wrong prescaler count moves every later short request. The error shows within one 768-cycle period, and the long request shifts by eight times that amount. A wrong value in the long-tick counter changes the spacing of the long request within one 6144-cycle period. A corrupted detector history shows within two short ticks: the detector request is raised early, raised twice for one episode, or never raised. A pending bit that is stuck high or stuck low shows on the first acknowledge or enable change that follows.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  typedef enum logic {
    MODE_USB_RST = 1'b0,
    MODE_PS2_ACT = 1'b1
  } det_mode_e;

  localparam int unsigned IRQ_FAST = 0;
  localparam int unsigned IRQ_SLOW = 1;
  localparam int unsigned IRQ_DET  = 2;
  localparam int unsigned NUM_IRQ  = 3;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned TICK_DIV   = 768,
  parameter int unsigned SLOW_RATIO = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic fast_tick_o,
  output logic slow_tick_o
);
  localparam int unsigned CW = $clog2(TICK_DIV);
  localparam int unsigned SW = $clog2(SLOW_RATIO);
  localparam logic [CW-1:0] CNT_LAST  = CW'(TICK_DIV - 1);
  localparam logic [SW-1:0] SLOW_LAST = SW'(SLOW_RATIO - 1);

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] slow_q;

  assign fast_tick_o = (cnt_q == CNT_LAST);
  assign slow_tick_o = fast_tick_o && (slow_q == SLOW_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      slow_q <= '0;
    end else begin
      cnt_q <= fast_tick_o ? '0 : cnt_q + 1'b1;
      if (fast_tick_o) slow_q <= slow_tick_o ? '0 : slow_q + 1'b1;
    end
  end
endmodule

// File: rtl/line_cond_detect.sv
module line_cond_detect
  import tick_irq_pkg::*;
#(
  parameter int unsigned DET_SAMPLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic mode_i,
  input  logic usb_dp_i,
  input  logic usb_dm_i,
  input  logic ps2_clk_i,
  input  logic ps2_dat_i,
  output logic hit_o
);
  localparam int unsigned HW = $clog2(DET_SAMPLES + 1);
  localparam logic [HW-1:0] HIST_FULL = HW'(DET_SAMPLES);

  logic          cond;
  logic [HW-1:0] hist_q;

  always_comb begin
    unique case (det_mode_e'(mode_i))
      MODE_USB_RST: cond = !usb_dp_i && !usb_dm_i;
      MODE_PS2_ACT: cond = !ps2_clk_i || !ps2_dat_i;
      default:      cond = 1'b0;
    endcase
  end

  // one event per episode: fire only on the sample that fills the history
  assign hit_o = tick_i && cond && (hist_q == HIST_FULL - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else if (tick_i) begin
      if (!cond)                   hist_q <= '0;
      else if (hist_q != HIST_FULL) hist_q <= hist_q + 1'b1;
    end
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic ack_i,
  output logic irq_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (!en_i) pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (ack_i) pend_q <= 1'b0;
  end

  assign irq_o = pend_q;
endmodule

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
  import tick_irq_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 768,
  parameter int unsigned SLOW_RATIO  = 8,
  parameter int unsigned DET_SAMPLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_en_i,
  input  logic slow_en_i,
  input  logic det_en_i,
  input  logic det_mode_i,
  input  logic usb_dp_i,
  input  logic usb_dm_i,
  input  logic ps2_clk_i,
  input  logic ps2_dat_i,
  input  logic fast_ack_i,
  input  logic slow_ack_i,
  input  logic det_ack_i,
  output logic fast_irq_o,
  output logic slow_irq_o,
  output logic det_irq_o
);
  logic fast_tick, slow_tick, det_hit;
  logic [NUM_IRQ-1:0] en_v, set_v, ack_v, irq_v;

  tick_prescaler #(.TICK_DIV(TICK_DIV), .SLOW_RATIO(SLOW_RATIO)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fast_tick_o(fast_tick), .slow_tick_o(slow_tick)
  );

  line_cond_detect #(.DET_SAMPLES(DET_SAMPLES)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(fast_tick), .mode_i(det_mode_i),
    .usb_dp_i(usb_dp_i), .usb_dm_i(usb_dm_i),
    .ps2_clk_i(ps2_clk_i), .ps2_dat_i(ps2_dat_i), .hit_o(det_hit)
  );

  assign en_v  = {det_en_i,  slow_en_i,  fast_en_i};
  assign set_v = {det_hit,   slow_tick,  fast_tick};
  assign ack_v = {det_ack_i, slow_ack_i, fast_ack_i};

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    irq_pending u_pend (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_v[i]),
      .set_i(set_v[i]), .ack_i(ack_v[i]), .irq_o(irq_v[i])
    );
  end

  assign fast_irq_o = irq_v[IRQ_FAST];
  assign slow_irq_o = irq_v[IRQ_SLOW];
  assign det_irq_o  = irq_v[IRQ_DET];
endmodule

// File: rtl/tick_irq_chk.sv
module tick_irq_chk #(
  parameter int unsigned TICK_DIV = 768
) (
  input logic clk_i,
  input logic rst_ni,
  input logic fast_tick_i,
  input logic slow_tick_i,
  input logic fast_en_i,
  input logic fast_ack_i,
  input logic det_en_i,
  input logic fast_irq_o,
  input logic slow_irq_o,
  input logic det_irq_o
);
  localparam int unsigned GW = $clog2(TICK_DIV + 1);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          gap_q <= '0;
    else if (fast_tick_i) gap_q <= '0;
    else                  gap_q <= gap_q + 1'b1;
  end

  AST_FAST_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_tick_i |-> (gap_q == GW'(TICK_DIV - 1))); // R2
  AST_SLOW_ON_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_tick_i |-> fast_tick_i); // R3
  AST_FAST_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_tick_i && fast_en_i) |=> fast_irq_o); // R2
  AST_HOLD_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_irq_o && fast_en_i && !fast_ack_i) |=> fast_irq_o); // R6
  AST_ACK_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_irq_o && fast_en_i && fast_ack_i && !fast_tick_i) |=> !fast_irq_o); // R6
  AST_EN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_en_i |=> !det_irq_o); // R7
  AST_SLOW_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slow_irq_o) |-> $past(slow_tick_i)); // R3
  AST_DET_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_irq_o) |-> $past(fast_tick_i)); // R5
endmodule

bind tick_irq_ctrl tick_irq_chk #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fast_tick_i(fast_tick), .slow_tick_i(slow_tick),
  .fast_en_i(fast_en_i), .fast_ack_i(fast_ack_i), .det_en_i(det_en_i),
  .fast_irq_o(fast_irq_o), .slow_irq_o(slow_irq_o), .det_irq_o(det_irq_o)
);

// File: tb/sim_tick_irq_ctrl.sv
`timescale 1ns/1ps
module sim_tick_irq_ctrl;
  localparam int DIV = 768;
  localparam int RATIO = 8;

  logic clk = 0, rst_n = 0;
  logic fen = 0, sen = 0, den = 0, mode = 0;
  logic dp = 1, dm = 1, pc = 1, pd = 1;
  logic fack = 0, sack = 0, dack = 0;
  logic firq, sirq, dirq;

  int checks = 0, errors = 0;
  bit done = 0, cmp_on = 0;
  int cyc = 0;

  int m_cnt, m_slow, m_hist;
  bit m_pf, m_ps, m_pd;

  always #4 clk = ~clk;

  tick_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .fast_en_i(fen), .slow_en_i(sen), .det_en_i(den),
    .det_mode_i(mode), .usb_dp_i(dp), .usb_dm_i(dm), .ps2_clk_i(pc), .ps2_dat_i(pd),
    .fast_ack_i(fack), .slow_ack_i(sack), .det_ack_i(dack),
    .fast_irq_o(firq), .slow_irq_o(sirq), .det_irq_o(dirq)
  );

  function automatic bit cond_f(bit md, bit a, bit b, bit c, bit d);
    return md ? (!c || !d) : (!a && !b); // R4
  endfunction

  function automatic bit pend_f(bit en, bit set, bit ack, bit cur);
    if (!en) return 0;
    if (set) return 1;
    if (ack) return 0;
    return cur;
  endfunction

  // reference model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_slow = 0; m_hist = 0; m_pf = 0; m_ps = 0; m_pd = 0;
    end else begin
      bit tk, stk, cnd, hit;
      cyc++;
      tk  = (m_cnt == DIV - 1);
      stk = tk && (m_slow == RATIO - 1);
      cnd = cond_f(mode, dp, dm, pc, pd);
      hit = tk && cnd && (m_hist == 1);
      m_cnt = tk ? 0 : m_cnt + 1;
      if (tk) m_slow = (m_slow + 1) % RATIO;
      if (tk) m_hist = cnd ? ((m_hist < 2) ? m_hist + 1 : 2) : 0;
      m_pf = pend_f(fen, tk, fack, m_pf);
      m_ps = pend_f(sen, stk, sack, m_ps);
      m_pd = pend_f(den, hit, dack, m_pd);
    end
  end

  task automatic chk(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0b expected=%0b", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on && !done) begin
    chk(firq, m_pf, "R2 fast_irq");
    chk(sirq, m_ps, "R3 slow_irq");
    chk(dirq, m_pd, "R5 det_irq");
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_hi(ref logic s);
    while (s !== 1'b1) @(negedge clk);
  endtask

  initial begin
    int t0, t1;
    bit seen;
    void'($urandom(32'h5eed_1234));
    step(3);
    chk(firq, 0, "R1 reset fast"); chk(sirq, 0, "R1 reset slow"); chk(dirq, 0, "R1 reset det");
    rst_n = 1;
    cmp_on = 1;
    // R2: spacing of short request
    fen = 1;
    wait_hi(firq); t0 = cyc; fack = 1; step(1); fack = 0;
    wait_hi(firq); t1 = cyc; fack = 1; step(1); fack = 0;
    chk(t1 - t0 == DIV, 1, "R2 fast period 768");
    // R3: spacing of long request
    sen = 1;
    wait_hi(sirq); t0 = cyc; sack = 1; step(1); sack = 0;
    wait_hi(sirq); t1 = cyc; sack = 1; step(1); sack = 0;
    chk(t1 - t0 == DIV * RATIO, 1, "R3 slow period 6144");
    // R7: disabling clears pending
    wait_hi(firq); fen = 0; step(1);
    chk(firq, 0, "R7 enable clear");
    step(2000);
    chk(firq, 0, "R7 stays low while disabled");
    sen = 0;
    // R4: only one USB line low does not count
    den = 1; mode = 0; dp = 0; dm = 1;
    seen = 0;
    for (int i = 0; i < 2000; i++) begin step(1); if (dirq) seen = 1; end
    chk(seen, 0, "R4 single line low ignored");
    // R5: both low fires within two ticks
    dm = 0; step(2 * DIV + 2);
    chk(dirq, 1, "R5 usb reset detected");
    dack = 1; step(1); dack = 0;
    seen = 0;
    for (int i = 0; i < 3 * DIV; i++) begin step(1); if (dirq) seen = 1; end
    chk(seen, 0, "R5 once per episode");
    dp = 1; dm = 1; step(DIV);
    // R4: PS/2 mode, clock low
    mode = 1; pc = 0; step(2 * DIV + 2);
    chk(dirq, 1, "R4 ps2 activity detected");
    dack = 1; step(1); dack = 0; pc = 1;
    // R6/R8 random phase
    fen = 1; sen = 1;
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      fack = ($urandom % 64) == 0;
      sack = ($urandom % 64) == 0;
      dack = ($urandom % 64) == 0;
      if (($urandom % 300) == 0) dp = ~dp;
      if (($urandom % 300) == 0) dm = ~dm;
      if (($urandom % 300) == 0) pc = ~pc;
      if (($urandom % 300) == 0) pd = ~pd;
      if (($urandom % 5000) == 0) fen = ~fen; // R8
      if (($urandom % 5000) == 0) sen = ~sen;
      if (($urandom % 5000) == 0) den = ~den;
      if (($urandom % 8000) == 0) mode = ~mode;
    end
    step(2);
    finish_run();
  end
endmodule